// File: doc/BRIEF.md
# Pseudo-static RAM configuration register capture

This block models the part of a pseudo-static RAM that loads its two configuration registers. One register holds the bus settings and the other holds the refresh settings. A register write is a normal asynchronous write cycle with the register-select pin held high. The value to store travels on the 22-bit address bus, not on the data lines. Address bit 19 chooses the target: high selects the bus register and low selects the refresh register. The value is committed on the first rising edge among chip enable, write enable and address-valid. Any rising edge that comes later in the same cycle is ignored.

A fast internal clock samples every pin through two-flop synchronizers and then detects the strobe edges. Both registers reset to parameterised defaults and drive outputs directly. Each register has a one-cycle pulse that marks every update. The memory array, refresh, burst-mode register writes and timing checks are outside this block.

Top module: `psram_cfg_loader`

## Requirements
- R1: While reset is low and after it is released, the bus register holds BUS_DEFAULT and the refresh register holds RFSH_DEFAULT until a register write is captured.
- R2: With the register-select pin `cfg_sel` low, no write or read cycle changes either register or raises an update pulse.
- R3: The stored value is the full 22-bit address bus value, sampled while chip enable, write enable and `cfg_sel` were all active, just before the capturing edge.
- R4: Address bit 19 high routes the value to the bus register and low routes it to the refresh register. The other register keeps its value.
- R5: Whichever of `ce_n`, `we_n` or `adv_n` rises first after the qualifying condition commits the write. Later rising edges are ignored until chip enable has returned high.
- R6: `lb_n` and `ub_n` have no effect on a register write.
- R7: A read cycle (`we_n` high, `oe_n` low) with `cfg_sel` high changes neither register and raises no pulse.
- R8: Each update raises exactly one one-cycle pulse, `bus_upd` or `rfsh_upd`, and the two never assert together.
- R9: A write is accepted only in standby. If `oe_n` is low while chip enable and write enable are low, the write is not accepted.
- R10: Strobes that rise together produce exactly one capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| adv_n | input | 1 | Address valid, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| lb_n | input | 1 | Lower byte enable, ignored |
| ub_n | input | 1 | Upper byte enable, ignored |
| cfg_sel | input | 1 | Register access select, active high |
| addr | input | 22 | Address bus; carries the register value |
| bus_cfg | output | 22 | Bus configuration register |
| rfsh_cfg | output | 22 | Refresh configuration register |
| bus_upd | output | 1 | One-cycle pulse on a bus register update |
| rfsh_upd | output | 1 | One-cycle pulse on a refresh register update |

## Verification
The assertions assume that the address bus and `cfg_sel` stay stable for several sampling cycles around each strobe transition. They also assume that each pin change lasts longer than the two synchronizer stages. The bench holds every pin level for four clocks. It changes the address only after the first rising strobe, and every cycle it drives ends with chip enable back high. Under those assumptions, a capture always follows a qualified cycle and a single edge can never be seen twice.

// File: rtl/psram_cfg_pkg.sv
// Package: shared sizes, defaults and the write-control state type.
// Assumes a 22-bit address bus with the register selector on bit 19.
package psram_cfg_pkg;
    localparam int ADDR_W    = 22;
    localparam int SEL_BIT   = 19;
    localparam logic [ADDR_W-1:0] BUS_DEF  = 22'h09_D1F;
    localparam logic [ADDR_W-1:0] RFSH_DEF = 22'h00_010;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_DONE  = 2'd2
    } wr_state_t;
endpackage

// File: rtl/psram_pin_sync.sv
// Two-flop synchronizer for a bundle of asynchronous pins.
// Assumes that each level lasts longer than two clocks; bits are not
// guaranteed to stay coherent with each other.
module psram_pin_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit, each reset to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/psram_strobe_edge.sv
// Rising-edge detector for N synchronized active-low strobes.
// Assumes the inputs are already synchronous to clk.
module psram_strobe_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] s,
    output logic [N-1:0] prev_low,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    // Keep the previous level of every strobe; reset treats them as high.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= s;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        // A rise is low in the previous cycle and high in the current one.
        always_comb rise[g] = s[g] & ~prev[g];
        always_comb prev_low[g] = ~prev[g];
    end
endmodule

// File: rtl/psram_cfg_wrctl.sv
// Register-write qualifier and capture controller.
// Arms when chip enable and write enable are low with cfg select high and
// output enable high. The first strobe rise while armed commits the held
// address. Rises after that are ignored until chip enable goes back high.
module psram_cfg_wrctl
    import psram_cfg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          we_s,
    input  logic          oe_s,
    input  logic          cre_s,
    input  logic [AW-1:0] addr_s,
    input  logic [2:0]    rise,
    output logic          capture,
    output logic [AW-1:0] cap_addr
);
    wr_state_t    state, state_nx;
    logic         qual;
    logic [AW-1:0] hold, hold_nx;

    // Qualifying level: write to a register, no array read driving.
    always_comb qual = cre_s & ~ce_s & ~we_s & oe_s;

    // Next state, the capture strobe and the held address.
    always_comb begin
        state_nx = state;
        hold_nx  = hold;
        capture  = 1'b0;
        unique case (state)
            WS_IDLE: begin
                if (qual) begin
                    state_nx = WS_ARMED;
                    hold_nx  = addr_s;
                end
            end
            WS_ARMED: begin
                if (|rise) begin
                    capture  = 1'b1;
                    state_nx = WS_DONE;
                end else if (!qual) begin
                    state_nx = WS_IDLE;
                end else begin
                    hold_nx = addr_s;
                end
            end
            WS_DONE: begin
                if (ce_s) state_nx = WS_IDLE;
            end
            default: state_nx = WS_IDLE;
        endcase
    end

    // State and held-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            hold  <= '0;
        end else begin
            state <= state_nx;
            hold  <= hold_nx;
        end
    end

    always_comb cap_addr = hold;

    // A capture needs cfg select, chip enable and write enable seen in the previous cycle.
    p_cap_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> ($past(cre_s) && !$past(ce_s) && !$past(we_s)));
    // Two captures never fall in consecutive cycles.
    p_single_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
    // No capture while output enable was low.
    p_standby_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(oe_s));
endmodule

// File: rtl/psram_cfg_bank.sv
// Holds the bus and refresh configuration registers with reset defaults.
// The select bit of the captured value picks the target register.
module psram_cfg_bank
    import psram_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SB = SEL_BIT,
    parameter logic [AW-1:0] BUS_DEFAULT  = BUS_DEF,
    parameter logic [AW-1:0] RFSH_DEFAULT = RFSH_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] cap_addr,
    output logic [AW-1:0] bus_q,
    output logic [AW-1:0] rfsh_q,
    output logic          bus_upd,
    output logic          rfsh_upd
);
    logic to_bus;

    always_comb to_bus = cap_addr[SB];

    // Load the chosen register and pulse its update flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q    <= BUS_DEFAULT;
            rfsh_q   <= RFSH_DEFAULT;
            bus_upd  <= 1'b0;
            rfsh_upd <= 1'b0;
        end else begin
            bus_upd  <= capture & to_bus;
            rfsh_upd <= capture & ~to_bus;
            if (capture && to_bus)  bus_q  <= cap_addr;
            if (capture && !to_bus) rfsh_q <= cap_addr;
        end
    end

    p_upd_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_upd, rfsh_upd}));
    p_bus_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd |=> !bus_upd);
    p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_upd |-> $stable(bus_q));
    p_rfsh_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_upd |-> $stable(rfsh_q));
endmodule

// File: rtl/psram_cfg_loader.sv
// Top: synchronizes the pins, detects strobe rises, qualifies register
// writes and loads the two configuration registers. Byte enables are
// accepted but play no part in a register write.
module psram_cfg_loader
    import psram_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SB = SEL_BIT,
    parameter logic [AW-1:0] BUS_DEFAULT  = BUS_DEF,
    parameter logic [AW-1:0] RFSH_DEFAULT = RFSH_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic          lb_n,
    input  logic          ub_n,
    input  logic          cfg_sel,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] bus_cfg,
    output logic [AW-1:0] rfsh_cfg,
    output logic          bus_upd,
    output logic          rfsh_upd
);
    localparam int NCTL = 5;
    localparam int NSTB = 3;

    logic [NCTL-1:0] ctl_s;
    logic [AW-1:0]   addr_s;
    logic [NSTB-1:0] stb_rise, stb_prev_low;
    logic            capture;
    logic [AW-1:0]   cap_addr;
    logic            unused_bytes;

    // R6: the byte enables are deliberately not used.
    always_comb unused_bytes = lb_n ^ ub_n;

    // Control pin order: {cfg_sel, oe_n, adv_n, we_n, ce_n}.
    psram_pin_sync #(.W(NCTL), .RST_VAL(5'b01111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cfg_sel, oe_n, adv_n, we_n, ce_n}), .q(ctl_s));

    psram_pin_sync #(.W(AW), .RST_VAL('0)) u_addr_sync (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));

    psram_strobe_edge #(.N(NSTB)) u_edge (
        .clk(clk), .rst_n(rst_n), .s(ctl_s[2:0]),
        .prev_low(stb_prev_low), .rise(stb_rise));

    psram_cfg_wrctl #(.AW(AW)) u_wrctl (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ctl_s[0]), .we_s(ctl_s[1]), .oe_s(ctl_s[3]), .cre_s(ctl_s[4]),
        .addr_s(addr_s), .rise(stb_rise),
        .capture(capture), .cap_addr(cap_addr));

    psram_cfg_bank #(.AW(AW), .SB(SB), .BUS_DEFAULT(BUS_DEFAULT),
                     .RFSH_DEFAULT(RFSH_DEFAULT)) u_bank (
        .clk(clk), .rst_n(rst_n), .capture(capture), .cap_addr(cap_addr),
        .bus_q(bus_cfg), .rfsh_q(rfsh_cfg),
        .bus_upd(bus_upd), .rfsh_upd(rfsh_upd));

    // Every capture coincides with a strobe that was low one cycle before.
    p_cap_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (|stb_prev_low));
    // An update pulse follows a capture whose select bit matches.
    p_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd |-> ($past(capture) && $past(cap_addr[SB])));
endmodule

// File: tb/psram_cfg_loader_bench.sv
module psram_cfg_loader_bench;
    localparam int AW = 22;
    localparam logic [AW-1:0] BDEF = 22'h09_D1F;
    localparam logic [AW-1:0] RDEF = 22'h00_010;

    logic clk = 0, rst_n = 0;
    logic ce_n = 1, we_n = 1, adv_n = 1, oe_n = 1, lb_n = 1, ub_n = 1, cfg_sel = 0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] bus_cfg, rfsh_cfg;
    logic bus_upd, rfsh_upd;

    int n_vec = 0, n_bad = 0, cnt_b = 0, cnt_r = 0, both = 0;
    logic [AW-1:0] exp_b, exp_r;
    int exp_cb = 0, exp_cr = 0;

    always #10 clk = ~clk;

    psram_cfg_loader u_psram_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .cfg_sel(cfg_sel), .addr(addr),
        .bus_cfg(bus_cfg), .rfsh_cfg(rfsh_cfg),
        .bus_upd(bus_upd), .rfsh_upd(rfsh_upd));

    // Count update pulses away from the active edge (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_upd)  cnt_b++;
            if (rfsh_upd) cnt_r++;
            if (bus_upd && rfsh_upd) both++;
        end
    end

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, bus_cfg, exp_b);
        chk(req, rfsh_cfg, exp_r);
        chk(req, AW'(cnt_b), AW'(exp_cb));
        chk(req, AW'(cnt_r), AW'(exp_cr));
        chk("R8", AW'(both), '0);
    endtask

    // Register write cycle; order picks which strobe rises first.
    // 0: CE first, 1: WE first then ADV, 2: ADV first, 3: all together.
    task automatic wr_cycle(input logic sel_pin, input logic [AW-1:0] val,
                            input int order, input logic oe_val, input logic [1:0] be);
        addr = val; cfg_sel = sel_pin; adv_n = 0; {lb_n, ub_n} = be; oe_n = oe_val;
        wait_clk(4);
        ce_n = 0; wait_clk(4);
        we_n = 0; wait_clk(4);
        case (order)
            0: begin ce_n = 1; wait_clk(4); addr = ~val; wait_clk(4);
                     we_n = 1; adv_n = 1; end
            1: begin we_n = 1; wait_clk(4); addr = ~val; wait_clk(4);
                     adv_n = 1; wait_clk(4); ce_n = 1; end
            2: begin adv_n = 1; wait_clk(4); addr = ~val; wait_clk(4);
                     we_n = 1; wait_clk(4); ce_n = 1; end
            default: begin ce_n = 1; we_n = 1; adv_n = 1; end
        endcase
        wait_clk(4);
        cfg_sel = 0; oe_n = 1; {lb_n, ub_n} = 2'b11;
        wait_clk(6);
    endtask

    initial begin
        exp_b = BDEF; exp_r = RDEF;
        wait_clk(3);
        check_all("R1");            // defaults while in reset
        rst_n = 1;
        wait_clk(4);
        check_all("R1");            // defaults after release

        // R2: array writes with cfg_sel low leave both registers alone
        for (int i = 0; i < 4; i++) begin
            wr_cycle(1'b0, AW'(i * 22'h1_3579) | 22'h8_0000, i, 1'b1, 2'b00);
            check_all("R2");
        end

        // R7: read with cfg_sel high
        for (int i = 0; i < 4; i++) begin
            addr = AW'(i * 22'h2_4681) ^ 22'h8_0000; cfg_sel = 1; adv_n = 0;
            wait_clk(4); ce_n = 0; oe_n = 0; wait_clk(4);
            adv_n = 1; wait_clk(4); oe_n = 1; ce_n = 1; wait_clk(4);
            cfg_sel = 0; wait_clk(4);
            check_all("R7");
        end

        // R9: output enable low during a write blocks it
        wr_cycle(1'b1, 22'h3F_FFFF, 0, 1'b0, 2'b11);
        check_all("R9");

        // R3 R4 R5 R6 R10: sweep of values, targets, strobe orders and byte enables
        for (int i = 0; i < 16; i++) begin
            for (int o = 0; o < 4; o++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [AW-1:0] v;
                    v = AW'((i * 4 + o) * 22'h2F_5A3 + s * 22'h1234 + 22'h5);
                    v[19] = s[0];
                    wr_cycle(1'b1, v, o, 1'b1, 2'(i));
                    if (s == 1) begin exp_b = v; exp_cb++; end
                    else        begin exp_r = v; exp_cr++; end
                    case (o)
                        0: check_all("R5");
                        1: check_all("R6");
                        2: check_all("R4");
                        default: check_all("R10");
                    endcase
                    chk("R3", s ? bus_cfg : rfsh_cfg, v);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: counted as a failure.
    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule